// File: doc/BRIEF.md
# Frame-Sync Serial Port (master)

This block is the master side of a four-wire serial link to an audio codec or similar peripheral. It takes parallel words from a transmit valid/ready handshake and shifts them out on a serial data line. At the same time it can shift in words from a receive line and present them through a receive valid/ready handshake. It generates the bit clock and the frame sync itself. The bit clock comes from a fixed divider of the system clock: each half of a bit period lasts `DIV_HALF` system clocks.

A frame has three parts, in this order: a programmable number of leading dummy clocks, the data bits, and a programmable number of trailing dummy clocks. Configuration inputs select:
- the word length;
- the frame-sync level, start period and length;
- the clock idle level;
- the half period on which transmit data changes and the instant at which receive data is sampled;
- full or half duplex;
- a free-run mode that keeps frames going with no transmit word.

The block reads these inputs only at the point where a frame may start. The bit clock toggles only inside frames.

Top module: `frame_sync_port`

## Requirements
- R1: A frame carries `cfg_bits_m1 + 1` data bits; a `cfg_bits_m1` value below 3 is treated as 3, so the shortest word is 4 bits and the longest is 32.
- R2: Data moves most significant bit first in both directions: bit `W-1` of `tx_data` is sent first, and the first bit received ends up in bit `W-1` of `rx_data`.
- R3: Outside frames `sck` holds `cfg_clk_idle`. Each active clock period lasts `2*DIV_HALF` system clocks: for the first `DIV_HALF` of them `sck` is at the inverse of the idle level, and for the rest it is at the idle level.
- R4: A frame lasts `cfg_pre_clks + W + cfg_post_clks` clock periods, counted from 0; data bit k (k = 0 first) belongs to period `cfg_pre_clks + k`.
- R5: `fs` is at level `cfg_sync_high` during periods `cfg_sync_delay` through `cfg_sync_delay + cfg_sync_len_m1`, cut short at the end of the frame. At all other times it is at the opposite level.
- R6: With `cfg_tx_late` = 0, `txd` carries bit k for the whole of period `cfg_pre_clks + k`. With `cfg_tx_late` = 1 the same window starts half a period later. `txd` is 0 at all other times.
- R7: With `cfg_rx_late` = 1, `rxd` is sampled in the last system clock of the first half of each data period. With 0, it is sampled in the last system clock of the period. `rx_data` holds the word right-justified, with zeros above it. `rx_valid` rises one system clock after the last sample and stays high until `rx_ready`; a newer word replaces one that has not been taken.
- R8: With `cfg_free_run` = 1 and reception enabled, frames start with no transmit word pending. These frames send zeros and follow one another with no gap, so the clock never pauses.
- R9: `tx_ready` is high only while no frame runs, or in the final system clock of a frame, and only when transmission is enabled. A word taken there starts a frame in the next system clock, and a new frame can follow the previous one with no gap.
- R10: With `cfg_full_duplex` = 1 both directions work in every frame. With 0, `cfg_half_rx` = 1 gives receive-only frames (`tx_ready` low, `txd` 0) and `cfg_half_rx` = 0 gives transmit-only frames (no `rx_valid`).
- R11: Configuration is captured when a frame starts; changing it during a frame affects only later frames (the idle levels of `sck` and `fs` follow the inputs directly).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bits_m1 | input | 5 | Word length minus one |
| cfg_sync_high | input | 1 | Frame-sync asserted level |
| cfg_sync_delay | input | 2 | First period with frame sync asserted |
| cfg_sync_len_m1 | input | 5 | Frame-sync length in periods minus one |
| cfg_clk_idle | input | 1 | Bit clock idle level |
| cfg_tx_late | input | 1 | Transmit data changes half a period later |
| cfg_rx_late | input | 1 | Select receive sample instant |
| cfg_pre_clks | input | 3 | Leading dummy clocks |
| cfg_post_clks | input | 3 | Trailing dummy clocks |
| cfg_full_duplex | input | 1 | Both directions in each frame |
| cfg_half_rx | input | 1 | Half duplex direction: 1 receive, 0 transmit |
| cfg_free_run | input | 1 | Run frames without transmit words |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken this cycle if valid |
| tx_data | input | 32 | Transmit word, right-justified |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word consumed |
| rx_data | output | 32 | Received word, right-justified |
| sck | output | 1 | Bit clock |
| fs | output | 1 | Frame sync |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The bench targets the seams between frames. Back-to-back and free-running frames must restart in the final system clock with no idle gap; a design that inserts a pause there stretches `sck` and misplaces every later bit. It also runs frame syncs that extend past the end of the frame, which a wrong design would let spill into the idle state. Further cases are the half-period shift of transmit data that runs past the final data period, and the 4-bit word-length clamp. Finally, the bench changes configuration mid-frame and holds `rx_ready` low so that a pending word gets overwritten. Errors there show up as corrupted sync windows, shifted bits, or a stale received word.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    localparam int WORD_MAX = 32;
    localparam int MIN_W    = 4;
    localparam int WLEN_W   = $clog2(WORD_MAX);
    localparam int DUMMY_W  = 3;
    localparam int DLY_W    = 2;
    localparam int PER_W    = $clog2(2 * ((1 << DUMMY_W) - 1) + WORD_MAX);

    typedef struct packed {
        logic [WLEN_W-1:0]  wlen_m1;
        logic               fs_act_hi;
        logic [DLY_W-1:0]   fs_dly;
        logic [WLEN_W-1:0]  fs_wid_m1;
        logic               clk_idle;
        logic               tx_late;
        logic               rx_late;
        logic [DUMMY_W-1:0] lead;
        logic [DUMMY_W-1:0] trail;
        logic               full_duplex;
        logic               half_rx;
    } fsp_cfg_t;

    function automatic logic tx_on(input logic full, input logic half_rx);
        return full | ~half_rx;
    endfunction

    function automatic logic rx_on(input logic full, input logic half_rx);
        return full | half_rx;
    endfunction
endpackage

// File: rtl/fsp_seq.sv
module fsp_seq
    import fsp_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  fsp_cfg_t           cfg_live,
    input  logic               free_run,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic               start,
    output logic               take,
    output logic               run,
    output logic [PER_W-1:0]   per,
    output logic               half,
    output logic               step,
    output logic [WLEN_W-1:0]  lat_wlen_m1,
    output logic [DUMMY_W-1:0] lat_lead,
    output logic               lat_tx_late,
    output logic               lat_rx_late,
    output logic               lat_tx_on,
    output logic               lat_rx_on,
    output logic               sck,
    output logic               fs
);
    localparam int HC_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    typedef struct packed {
        logic             run;
        logic             half;
        logic [HC_W-1:0]  hcnt;
        logic [PER_W-1:0] per;
        fsp_cfg_t         cfg;
    } seq_st_t;

    seq_st_t          s_d, s_q;
    logic             at_end, boundary, go, tx_en_live, rx_en_live, in_win;
    logic [PER_W-1:0] last_per;
    logic [PER_W:0]   win_hi;
    fsp_cfg_t         cfg_clamped;

    always_comb begin
        tx_en_live = tx_on(cfg_live.full_duplex, cfg_live.half_rx);
        rx_en_live = rx_on(cfg_live.full_duplex, cfg_live.half_rx);
        step       = (s_q.hcnt == HC_W'(DIV_HALF - 1));
        last_per   = PER_W'(s_q.cfg.lead) + PER_W'(s_q.cfg.wlen_m1) + PER_W'(s_q.cfg.trail);
        at_end     = s_q.run & step & s_q.half & (s_q.per == last_per);
        boundary   = ~s_q.run | at_end;
        go         = (tx_en_live & tx_valid) | (free_run & rx_en_live);

        cfg_clamped = cfg_live;
        if (cfg_live.wlen_m1 < WLEN_W'(MIN_W - 1))
            cfg_clamped.wlen_m1 = WLEN_W'(MIN_W - 1);

        s_d = s_q;
        if (s_q.run) begin
            if (step) begin
                s_d.hcnt = '0;
                s_d.half = ~s_q.half;
                if (s_q.half)
                    s_d.per = s_q.per + PER_W'(1);
            end else begin
                s_d.hcnt = s_q.hcnt + HC_W'(1);
            end
        end
        if (boundary) begin
            s_d.run = go;
            if (go) begin
                s_d.hcnt = '0;
                s_d.half = 1'b0;
                s_d.per  = '0;
                s_d.cfg  = cfg_clamped;
            end
        end

        win_hi = (PER_W+1)'(s_q.cfg.fs_dly) + (PER_W+1)'(s_q.cfg.fs_wid_m1);
        in_win = ((PER_W+1)'(s_q.per) >= (PER_W+1)'(s_q.cfg.fs_dly)) &&
                 ((PER_W+1)'(s_q.per) <= win_hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start       = boundary & go;
    assign tx_ready    = boundary & tx_en_live;
    assign take        = boundary & tx_en_live & tx_valid;
    assign run         = s_q.run;
    assign per         = s_q.per;
    assign half        = s_q.half;
    assign lat_wlen_m1 = s_q.cfg.wlen_m1;
    assign lat_lead    = s_q.cfg.lead;
    assign lat_tx_late = s_q.cfg.tx_late;
    assign lat_rx_late = s_q.cfg.rx_late;
    assign lat_tx_on   = tx_on(s_q.cfg.full_duplex, s_q.cfg.half_rx);
    assign lat_rx_on   = rx_on(s_q.cfg.full_duplex, s_q.cfg.half_rx);
    assign sck = s_q.run ? (s_q.half ? s_q.cfg.clk_idle : ~s_q.cfg.clk_idle) : cfg_live.clk_idle;
    assign fs  = s_q.run ? (in_win ? s_q.cfg.fs_act_hi : ~s_q.cfg.fs_act_hi) : ~cfg_live.fs_act_hi;

    // R4
    per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.per <= last_per));
    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !start) |=> $stable(s_q.cfg));
    // R3
    sck_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !step) |=> $stable(sck));
endmodule

// File: rtl/fsp_tx.sv
module fsp_tx
    import fsp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                take,
    input  logic [WORD_MAX-1:0] tx_data,
    input  logic                run,
    input  logic [PER_W-1:0]    per,
    input  logic                half,
    input  logic [WLEN_W-1:0]   wlen_m1,
    input  logic [DUMMY_W-1:0]  lead,
    input  logic                tx_late,
    input  logic                tx_en,
    output logic                txd
);
    localparam int SW = PER_W + 1;

    typedef struct packed {
        logic [WORD_MAX-1:0] word;
    } tx_st_t;

    tx_st_t            t_d, t_q;
    logic [SW-1:0]     slot, launch, bitn, lo, hi;
    logic [WLEN_W-1:0] idx;
    logic              launch_ok, in_data;

    always_comb begin
        t_d = t_q;
        if (start)
            t_d.word = take ? tx_data : '0;

        slot      = {per, half};
        launch    = slot - SW'(tx_late);
        launch_ok = ~(tx_late & (slot == '0));
        bitn      = launch >> 1;
        lo        = SW'(lead);
        hi        = SW'(lead) + SW'(wlen_m1);
        in_data   = (bitn >= lo) && (bitn <= hi);
        idx       = WLEN_W'(hi - bitn);
        txd       = run & launch_ok & in_data & t_q.word[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R10
    rx_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tx_en) |-> !txd);
endmodule

// File: rtl/fsp_rx.sv
module fsp_rx
    import fsp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                run,
    input  logic [PER_W-1:0]    per,
    input  logic                half,
    input  logic                step,
    input  logic [WLEN_W-1:0]   wlen_m1,
    input  logic [DUMMY_W-1:0]  lead,
    input  logic                rx_late,
    input  logic                rx_en,
    input  logic                rxd,
    input  logic                rx_ready,
    output logic                rx_valid,
    output logic [WORD_MAX-1:0] rx_data
);
    typedef struct packed {
        logic [WORD_MAX-2:0] sh;
        logic [WORD_MAX-1:0] hold;
        logic                done;
        logic                valid;
        logic [WORD_MAX-1:0] data;
    } rx_st_t;

    rx_st_t              r_d, r_q;
    logic [PER_W-1:0]    first_p, last_p;
    logic                samp, last_samp;
    logic [WORD_MAX-1:0] shifted;

    always_comb begin
        first_p   = PER_W'(lead);
        last_p    = PER_W'(lead) + PER_W'(wlen_m1);
        samp      = run & rx_en & step & (half == ~rx_late) & (per >= first_p) & (per <= last_p);
        last_samp = samp & (per == last_p);
        shifted   = {r_q.sh, rxd};

        r_d = r_q;
        if (r_q.done) begin
            r_d.data  = r_q.hold;
            r_d.valid = 1'b1;
        end else if (r_q.valid && rx_ready) begin
            r_d.valid = 1'b0;
        end
        r_d.done = last_samp;
        if (samp) begin
            r_d.sh = shifted[WORD_MAX-2:0];
            if (last_samp)
                r_d.hold = shifted;
        end
        if (start)
            r_d.sh = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_valid = r_q.valid;
    assign rx_data  = r_q.data;

    // R7
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> rx_valid);
endmodule

// File: rtl/frame_sync_port.sv
module frame_sync_port
    import fsp_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WLEN_W-1:0]   cfg_bits_m1,
    input  logic                cfg_sync_high,
    input  logic [DLY_W-1:0]    cfg_sync_delay,
    input  logic [WLEN_W-1:0]   cfg_sync_len_m1,
    input  logic                cfg_clk_idle,
    input  logic                cfg_tx_late,
    input  logic                cfg_rx_late,
    input  logic [DUMMY_W-1:0]  cfg_pre_clks,
    input  logic [DUMMY_W-1:0]  cfg_post_clks,
    input  logic                cfg_full_duplex,
    input  logic                cfg_half_rx,
    input  logic                cfg_free_run,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic [WORD_MAX-1:0] tx_data,
    output logic                rx_valid,
    input  logic                rx_ready,
    output logic [WORD_MAX-1:0] rx_data,
    output logic                sck,
    output logic                fs,
    output logic                txd,
    input  logic                rxd
);
    fsp_cfg_t           cfg_live;
    logic               start, take, run, half, step;
    logic [PER_W-1:0]   per;
    logic [WLEN_W-1:0]  l_wlen_m1;
    logic [DUMMY_W-1:0] l_lead;
    logic               l_tx_late, l_rx_late, l_tx_on, l_rx_on;

    always_comb begin
        cfg_live.wlen_m1     = cfg_bits_m1;
        cfg_live.fs_act_hi   = cfg_sync_high;
        cfg_live.fs_dly      = cfg_sync_delay;
        cfg_live.fs_wid_m1   = cfg_sync_len_m1;
        cfg_live.clk_idle    = cfg_clk_idle;
        cfg_live.tx_late     = cfg_tx_late;
        cfg_live.rx_late     = cfg_rx_late;
        cfg_live.lead        = cfg_pre_clks;
        cfg_live.trail       = cfg_post_clks;
        cfg_live.full_duplex = cfg_full_duplex;
        cfg_live.half_rx     = cfg_half_rx;
    end

    fsp_seq #(.DIV_HALF(DIV_HALF)) i_seq (
        .clk(clk), .rst_n(rst_n), .cfg_live(cfg_live), .free_run(cfg_free_run),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .start(start), .take(take),
        .run(run), .per(per), .half(half), .step(step),
        .lat_wlen_m1(l_wlen_m1), .lat_lead(l_lead), .lat_tx_late(l_tx_late),
        .lat_rx_late(l_rx_late), .lat_tx_on(l_tx_on), .lat_rx_on(l_rx_on),
        .sck(sck), .fs(fs)
    );

    fsp_tx i_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .take(take), .tx_data(tx_data),
        .run(run), .per(per), .half(half), .wlen_m1(l_wlen_m1), .lead(l_lead),
        .tx_late(l_tx_late), .tx_en(l_tx_on), .txd(txd)
    );

    fsp_rx i_rx (
        .clk(clk), .rst_n(rst_n), .start(start), .run(run), .per(per), .half(half),
        .step(step), .wlen_m1(l_wlen_m1), .lead(l_lead), .rx_late(l_rx_late),
        .rx_en(l_rx_on), .rxd(rxd), .rx_ready(rx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data)
    );
endmodule

// File: tb/test_frame_sync_port.sv
module test_frame_sync_port;
    localparam int CLK_PERIOD = 10;
    localparam int D = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] cfg_bits_m1, cfg_sync_len_m1;
    logic [1:0] cfg_sync_delay;
    logic [2:0] cfg_pre_clks, cfg_post_clks;
    logic cfg_sync_high, cfg_clk_idle, cfg_tx_late, cfg_rx_late;
    logic cfg_full_duplex, cfg_half_rx, cfg_free_run;
    logic tx_valid, tx_ready, rx_valid, rx_ready, sck, fs, txd, rxd;
    logic [31:0] tx_data, rx_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;
    bit checking = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_sync_port #(.DIV_HALF(D)) i_frame_sync_port (
        .clk(clk), .rst_n(rst_n), .cfg_bits_m1(cfg_bits_m1), .cfg_sync_high(cfg_sync_high),
        .cfg_sync_delay(cfg_sync_delay), .cfg_sync_len_m1(cfg_sync_len_m1),
        .cfg_clk_idle(cfg_clk_idle), .cfg_tx_late(cfg_tx_late), .cfg_rx_late(cfg_rx_late),
        .cfg_pre_clks(cfg_pre_clks), .cfg_post_clks(cfg_post_clks),
        .cfg_full_duplex(cfg_full_duplex), .cfg_half_rx(cfg_half_rx),
        .cfg_free_run(cfg_free_run), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .sck(sck), .fs(fs), .txd(txd), .rxd(rxd)
    );

    // behavioural reference state
    logic [31:0] txq[$];
    bit m_run = 0;
    int j = 0, flen = 0, w = 0, lead = 0, trail = 0, dly = 0, wid = 0;
    bit act, cpol, txl, rxl, txact, rxact;
    logic [31:0] mword = 0, acc = 0, mhold = 0, mdata = 0, nh = 0;
    bit mpend = 0, mvalid = 0;

    task automatic chk1(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        bit tl, rl, bnd, go, e_sck, e_fs, e_txd, newdone;
        int p, hs, s, b;
        if (checking) begin
            tl  = cfg_full_duplex | !cfg_half_rx;
            rl  = cfg_full_duplex | cfg_half_rx;
            bnd = !m_run || (j == flen - 1);
            p   = j / (2 * D);
            hs  = j / D;
            if (m_run) begin
                e_sck = (hs % 2 == 0) ? !cpol : cpol;
                e_fs  = (p >= dly && p < dly + wid) ? act : !act;
                s     = txl ? hs - 1 : hs;
                b     = (s >= 0) ? s / 2 - lead : -1;
                e_txd = (s >= 0 && b >= 0 && b < w) ? mword[w-1-b] : 1'b0;
            end else begin
                e_sck = cfg_clk_idle;
                e_fs  = !cfg_sync_high;
                e_txd = 1'b0;
            end
            chk1("R3 R4 R8 sck", sck, e_sck);
            chk1("R5 R11 fs", fs, e_fs);
            chk1("R2 R6 txd", txd, e_txd);
            chk1("R9 R10 tx_ready", tx_ready, bnd && tl);
            chk1("R7 R10 rx_valid", rx_valid, mvalid);
            if (mvalid) chk1("R1 R2 R7 rx_data", rx_data, mdata);

            newdone = 0;
            if (m_run && rxact && (j % D == D - 1) && ((hs % 2) == (rxl ? 0 : 1)) &&
                p >= lead && p < lead + w) begin
                acc = {acc[30:0], rxd};
                if (p == lead + w - 1) begin newdone = 1; nh = acc; end
            end
            if (mpend) begin mdata = mhold; mvalid = 1; end
            else if (mvalid && rx_ready) mvalid = 0;
            mpend = newdone;
            if (newdone) mhold = nh;

            go = (tl && tx_valid) || (cfg_free_run && rl);
            if (bnd) begin
                if (go) begin
                    m_run = 1; j = 0;
                    w = (int'(cfg_bits_m1) + 1 < 4) ? 4 : int'(cfg_bits_m1) + 1;
                    lead = int'(cfg_pre_clks); trail = int'(cfg_post_clks);
                    dly = int'(cfg_sync_delay); wid = int'(cfg_sync_len_m1) + 1;
                    act = cfg_sync_high; cpol = cfg_clk_idle;
                    txl = cfg_tx_late; rxl = cfg_rx_late; txact = tl; rxact = rl;
                    flen = 2 * D * (lead + w + trail);
                    acc = 0;
                    if (tl && tx_valid) mword = txq.pop_front();
                    else mword = 0;
                end else m_run = 0;
            end else j++;
        end
    end

    // input driver: handshake data and pseudo-random serial receive line
    initial begin
        tx_valid = 0; tx_data = 0; rxd = 0;
        forever begin
            @(posedge clk); #2;
            tx_valid = (txq.size() > 0);
            tx_data  = (txq.size() > 0) ? txq[0] : 32'h0;
            rxd      = lfsr[0];
            lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    end

    task automatic setc(input int bm1, input bit hi, input int dl, input int wm1, input bit idle,
                        input bit tlate, input bit rlate, input int pre, input int post,
                        input bit fd, input bit hrx, input bit fr);
        @(posedge clk); #1;
        cfg_bits_m1 = 5'(bm1); cfg_sync_high = hi; cfg_sync_delay = 2'(dl);
        cfg_sync_len_m1 = 5'(wm1); cfg_clk_idle = idle; cfg_tx_late = tlate;
        cfg_rx_late = rlate; cfg_pre_clks = 3'(pre); cfg_post_clks = 3'(post);
        cfg_full_duplex = fd; cfg_half_rx = hrx; cfg_free_run = fr;
    endtask

    task automatic wait_idle();
        do @(posedge clk); while (txq.size() > 0 || m_run);
        repeat (6) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got running expected finished at %0t", $time);
        report();
    end

    initial begin
        rx_ready = 1;
        cfg_bits_m1 = 7; cfg_sync_high = 1; cfg_sync_delay = 0; cfg_sync_len_m1 = 0;
        cfg_clk_idle = 0; cfg_tx_late = 0; cfg_rx_late = 1; cfg_pre_clks = 0;
        cfg_post_clks = 0; cfg_full_duplex = 1; cfg_half_rx = 0; cfg_free_run = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk1("R3 reset sck", sck, 1'b0);
        chk1("R6 reset txd", txd, 1'b0);
        chk1("R7 reset rx_valid", rx_valid, 1'b0);
        @(posedge clk); #1;
        rst_n = 1;
        checking = 1;
        repeat (5) @(posedge clk);

        // R1 R2 R4 R9: 8-bit words back to back, plain timing
        txq.push_back(32'hA5); txq.push_back(32'h3C); txq.push_back(32'hFF01);
        wait_idle();

        // R3 R5 R6 R7 R11: 16-bit, inverted clock and sync, late edges, dummies, mid-frame change
        setc(15, 0, 1, 15, 1, 1, 0, 2, 3, 1, 0, 0);
        txq.push_back(32'hBEEF); txq.push_back(32'h1234);
        repeat (30) @(posedge clk);
        setc(11, 1, 2, 4, 0, 0, 1, 1, 1, 1, 0, 0);
        wait_idle();

        // R5 R1: 32-bit word, sync window running past frame end
        setc(31, 1, 3, 31, 0, 1, 1, 0, 1, 1, 0, 0);
        txq.push_back(32'hDEADBEEF); txq.push_back(32'h80000001);
        wait_idle();

        // R1: length field below minimum treated as 4 bits
        setc(1, 1, 0, 1, 1, 0, 0, 1, 0, 1, 0, 0);
        txq.push_back(32'h9); txq.push_back(32'h6);
        wait_idle();

        // R10: transmit-only half duplex
        setc(9, 0, 0, 2, 0, 1, 0, 0, 2, 0, 0, 0);
        txq.push_back(32'h2AA); txq.push_back(32'h155);
        wait_idle();

        // R8 R10 R7: receive-only free run, stalled consumer causes overwrite
        setc(5, 1, 1, 0, 1, 0, 1, 1, 1, 0, 1, 1);
        repeat (60) @(posedge clk);
        #1 rx_ready = 0;
        repeat (150) @(posedge clk);
        #1 rx_ready = 1;
        repeat (40) @(posedge clk);
        setc(5, 1, 1, 0, 1, 0, 1, 1, 1, 0, 1, 0);
        wait_idle();

        // R8 R9 R11: full-duplex free run with words arriving while frames run
        setc(7, 1, 0, 3, 0, 0, 0, 7, 7, 1, 0, 1);
        repeat (100) @(posedge clk);
        txq.push_back(32'hC3);
        repeat (150) @(posedge clk);
        txq.push_back(32'h5A); txq.push_back(32'h81);
        repeat (200) @(posedge clk);
        setc(12, 0, 2, 31, 1, 1, 0, 3, 0, 1, 0, 0);
        txq.push_back(32'h1F0F);
        wait_idle();

        report();
    end
endmodule